// File: doc/BRIEF.md
# Clock Output Mode Controller

This block holds the control logic of a two-output clock generator: one frequency-modulated output and one plain reference output. It decides where each setting comes from and turns the result into output-stage controls. A source-select bit chooses one of two origins for the whole configuration: strap pins or software register bits. The configuration covers input range, output range, modulation width and spread on/off.

The chosen range codes are decoded into a multiplier exponent, so the output-to-input ratio is 2 to the power of that exponent. An output-range code of zero does not select a frequency. It is a power-down request, and the upper two modulation-width bits then pick how both outputs behave: floated, held low or held high.

Each output gets three registered controls: pass-clock, static drive level and high-impedance. These registers update only on the falling edge of the clock being gated, so a pulse is never cut short. The modulated output is also held back until the PLL has reported lock since it last started.

Top module: `outclk_mode_ctrl`

## Requirements
- R1: With `sel_sw` = 0 the range, width and spread settings come from the `pin_*` inputs and the `reg_*` versions are ignored; with `sel_sw` = 1 the reverse holds.
- R2: For input-range code i in {01,10,11} and output-range code o in {01,10,11}, `mult_exp` is the 3-bit two's-complement value of o minus i (01 gives 000, 01→11 gives 010, 11→01 gives 110, 11→10 gives 111, 10→11 gives 001).
- R3: An input-range code of 00 is invalid: `mult_exp` reads 100 and the modulated output is held low ({en,lvl,hiz} = 000), while the reference output is unaffected.
- R4: An output-range code of 00 is power-down. `mult_exp` reads 100, and width bits [2:1] set both outputs regardless of their enables: 10 floats them ({en,lvl,hiz} = 001), 00 drives them high (010), and 11 or the reserved 01 drives them low (000).
- R5: Outside power-down, an output whose enable bit (`reg_ss_en`, `reg_ref_en`, 1 = enabled) is 0 is actively held low (000), not floated; an enabled output passes its clock (100).
- R6: `pll_run` is 1 only when `reg_pll_run` is 1 and the effective output-range code is not 00.
- R7: `spread_on` is 1 when the effective spread control is 0 (`pin_spread_n` low, or `reg_spread_off` low), and `spread_width` carries the effective 3-bit width.
- R8: The modulated output passes its clock only after `pll_locked` has been seen while the PLL runs; that flag is sticky until `pll_run` drops, which clears it.
- R9: All output controls change on the falling clock edge only; a setting applied after a rising edge is not visible until the following falling edge.
- R10: During reset both outputs read 000, `mult_exp` reads 100, and `pll_run` and `spread_on` read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock whose output pulses are gated; all state updates on its falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_sw | input | 1 | Configuration source: 0 pins, 1 register bits |
| pin_irange | input | 2 | Strapped input-range code |
| pin_orange | input | 2 | Strapped output-range code |
| pin_mwidth | input | 3 | Strapped modulation width |
| pin_spread_n | input | 1 | Strapped spread control, 0 = spread on |
| reg_irange | input | 2 | Register input-range code |
| reg_orange | input | 2 | Register output-range code |
| reg_mwidth | input | 3 | Register modulation width |
| reg_spread_off | input | 1 | Register spread control, 0 = spread on |
| reg_pll_run | input | 1 | Register PLL run bit, 1 = run |
| reg_ss_en | input | 1 | Enable of the modulated output, 1 = enabled |
| reg_ref_en | input | 1 | Enable of the reference output, 1 = enabled |
| pll_locked | input | 1 | Lock status from the PLL |
| pll_run | output | 1 | PLL run request |
| mult_exp | output | 3 | Multiplier exponent, two's complement; 100 = no frequency |
| spread_on | output | 1 | Modulation active |
| spread_width | output | 3 | Effective modulation width |
| ss_en | output | 1 | Modulated output passes clock |
| ss_lvl | output | 1 | Modulated output static level when not passing |
| ss_hiz | output | 1 | Modulated output high impedance |
| ref_en | output | 1 | Reference output passes clock |
| ref_lvl | output | 1 | Reference output static level when not passing |
| ref_hiz | output | 1 | Reference output high impedance |

## Verification
The bench builds the block with its default parameters: 2-bit range codes, a 3-bit width and a 3-bit exponent. These sizes make every range pair reachable, from the 0.25 ratio to the 4x ratio, along with all four power-down selections and the invalid input-range code. Stimulus sets the pins and the register bits to conflicting values, so that a wrong source is visible at the outputs. The lock sequence stops and restarts the PLL to show both the sticky behaviour and the clearing of the flag. A drive placed between edges shows that nothing moves before the falling edge.

// File: rtl/outclk_pkg.sv
package outclk_pkg;

   // Power-down selection taken from the upper width bits
   typedef enum logic [1:0] {
      PD_HIGH = 2'b00,
      PD_RSVD = 2'b01,
      PD_HIZ  = 2'b10,
      PD_LOW  = 2'b11
   } pd_mode_e;

   // Output-stage control word
   typedef struct packed {
      logic en;   // pass the clock
      logic lvl;  // static level when not passing
      logic hiz;  // float the pad
   } out_ctl_t;

   localparam out_ctl_t CTL_LOW  = '{en: 1'b0, lvl: 1'b0, hiz: 1'b0};
   localparam out_ctl_t CTL_HIGH = '{en: 1'b0, lvl: 1'b1, hiz: 1'b0};
   localparam out_ctl_t CTL_HIZ  = '{en: 1'b0, lvl: 1'b0, hiz: 1'b1};
   localparam out_ctl_t CTL_RUN  = '{en: 1'b1, lvl: 1'b0, hiz: 1'b0};

endpackage

// File: rtl/outclk_cfg_select.sv
module outclk_cfg_select #(
   parameter int W = 8
) (
   input  logic         use_sw,
   input  logic [W-1:0] pin_vec,
   input  logic [W-1:0] sw_vec,
   output logic [W-1:0] eff_vec
);

   generate
      if (W < 1) begin : g_bad_w
         $error("outclk_cfg_select: W must be positive");
      end
   endgenerate

   always_comb begin
      eff_vec = use_sw ? sw_vec : pin_vec;
   end

endmodule

// File: rtl/outclk_range_decode.sv
module outclk_range_decode
   import outclk_pkg::*;
#(
   parameter int IR_W  = 2,
   parameter int OR_W  = 2,
   parameter int EXP_W = 3
) (
   input  logic [IR_W-1:0]  irange,
   input  logic [OR_W-1:0]  orange,
   input  logic [1:0]       mw_hi,
   output logic             pd_active,
   output pd_mode_e         pd_mode,
   output logic             ir_valid,
   output logic [EXP_W-1:0] mult_exp
);

   localparam logic [EXP_W-1:0] NO_FREQ = EXP_W'(1) << (EXP_W - 1);

   generate
      if (EXP_W <= IR_W || EXP_W <= OR_W) begin : g_bad_exp
         $error("outclk_range_decode: EXP_W must exceed both range widths");
      end
   endgenerate

   logic [EXP_W-1:0] diff;

   always_comb begin
      pd_active = (orange == '0);
      ir_valid  = (irange != '0);
      pd_mode   = pd_mode_e'(mw_hi);
      diff      = EXP_W'(orange) - EXP_W'(irange);
      mult_exp  = (pd_active || !ir_valid) ? NO_FREQ : diff;
   end

endmodule

// File: rtl/outclk_out_stage.sv
module outclk_out_stage
   import outclk_pkg::*;
#(
   parameter bit NEED_LOCK = 1'b1
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     pd_active,
   input  pd_mode_e pd_mode,
   input  logic     sw_en,
   input  logic     cfg_ok,
   input  logic     lock_ok,
   output out_ctl_t ctl_q
);

   logic     path_ok;
   out_ctl_t ctl_d;

   generate
      if (NEED_LOCK) begin : g_lock_gate
         assign path_ok = cfg_ok & lock_ok;
         // R8: a passing modulated output implies lock was seen
         assert_pass_needs_lock_R8: assert property (@(negedge clk) disable iff (!rst_n)
            ctl_q.en |-> $past(lock_ok));
      end else begin : g_free_run
         logic unused_lock_ok;
         assign unused_lock_ok = lock_ok;
         assign path_ok = cfg_ok;
      end
   endgenerate

   always_comb begin
      if (pd_active) begin
         unique case (pd_mode)
            PD_HIZ:  ctl_d = CTL_HIZ;
            PD_HIGH: ctl_d = CTL_HIGH;
            default: ctl_d = CTL_LOW;
         endcase
      end else if (!sw_en || !path_ok) begin
         ctl_d = CTL_LOW;
      end else begin
         ctl_d = CTL_RUN;
      end
   end

   // falling-edge update keeps every high phase whole
   always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) ctl_q <= CTL_LOW;
      else        ctl_q <= ctl_d;
   end

   // R4: a floated output never also drives
   assert_hiz_exclusive_R4: assert property (@(negedge clk) disable iff (!rst_n)
      ctl_q.hiz |-> (!ctl_q.en && !ctl_q.lvl));

   // R5: a disabled output outside power-down is held low, not floated
   assert_disabled_low_R5: assert property (@(negedge clk) disable iff (!rst_n)
      (!pd_active && !sw_en) |=> (ctl_q == CTL_LOW));

endmodule

// File: rtl/outclk_mode_ctrl.sv
module outclk_mode_ctrl
   import outclk_pkg::*;
#(
   parameter int IR_W  = 2,
   parameter int OR_W  = 2,
   parameter int MW_W  = 3,
   parameter int EXP_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sel_sw,
   input  logic [IR_W-1:0]  pin_irange,
   input  logic [OR_W-1:0]  pin_orange,
   input  logic [MW_W-1:0]  pin_mwidth,
   input  logic             pin_spread_n,
   input  logic [IR_W-1:0]  reg_irange,
   input  logic [OR_W-1:0]  reg_orange,
   input  logic [MW_W-1:0]  reg_mwidth,
   input  logic             reg_spread_off,
   input  logic             reg_pll_run,
   input  logic             reg_ss_en,
   input  logic             reg_ref_en,
   input  logic             pll_locked,
   output logic             pll_run,
   output logic [EXP_W-1:0] mult_exp,
   output logic             spread_on,
   output logic [MW_W-1:0]  spread_width,
   output logic             ss_en,
   output logic             ss_lvl,
   output logic             ss_hiz,
   output logic             ref_en,
   output logic             ref_lvl,
   output logic             ref_hiz
);

   localparam int CFG_W = IR_W + OR_W + MW_W + 1;
   localparam logic [EXP_W-1:0] NO_FREQ = EXP_W'(1) << (EXP_W - 1);

   generate
      if (MW_W < 2) begin : g_bad_mw
         $error("outclk_mode_ctrl: MW_W must be at least 2");
      end
   endgenerate

   // ---- source selection ----
   logic [CFG_W-1:0] cfg_eff;
   logic [IR_W-1:0]  eff_ir;
   logic [OR_W-1:0]  eff_or;
   logic [MW_W-1:0]  eff_mw;
   logic             eff_spread_off;

   outclk_cfg_select #(.W(CFG_W)) u_sel (
      .use_sw  (sel_sw),
      .pin_vec ({pin_irange, pin_orange, pin_mwidth, pin_spread_n}),
      .sw_vec  ({reg_irange, reg_orange, reg_mwidth, reg_spread_off}),
      .eff_vec (cfg_eff)
   );

   assign {eff_ir, eff_or, eff_mw, eff_spread_off} = cfg_eff;

   // ---- range decode ----
   logic             pd_active;
   pd_mode_e         pd_mode;
   logic             ir_valid;
   logic [EXP_W-1:0] mult_d;

   outclk_range_decode #(.IR_W(IR_W), .OR_W(OR_W), .EXP_W(EXP_W)) u_dec (
      .irange    (eff_ir),
      .orange    (eff_or),
      .mw_hi     (eff_mw[MW_W-1 -: 2]),
      .pd_active (pd_active),
      .pd_mode   (pd_mode),
      .ir_valid  (ir_valid),
      .mult_exp  (mult_d)
   );

   // ---- shared control registers ----
   logic             pll_run_q;
   logic             lock_seen;
   logic [EXP_W-1:0] mult_q;
   logic             spread_q;
   logic [MW_W-1:0]  width_q;

   always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pll_run_q <= 1'b0;
         lock_seen <= 1'b0;
         mult_q    <= NO_FREQ;
         spread_q  <= 1'b0;
         width_q   <= '0;
      end else begin
         pll_run_q <= reg_pll_run & ~pd_active;
         lock_seen <= pll_run_q & (lock_seen | pll_locked);
         mult_q    <= mult_d;
         spread_q  <= ~eff_spread_off;
         width_q   <= eff_mw;
      end
   end

   // ---- per-output stages ----
   out_ctl_t ss_ctl;
   out_ctl_t ref_ctl;

   outclk_out_stage #(.NEED_LOCK(1'b1)) u_ss_stage (
      .clk       (clk),
      .rst_n     (rst_n),
      .pd_active (pd_active),
      .pd_mode   (pd_mode),
      .sw_en     (reg_ss_en),
      .cfg_ok    (ir_valid),
      .lock_ok   (lock_seen),
      .ctl_q     (ss_ctl)
   );

   outclk_out_stage #(.NEED_LOCK(1'b0)) u_ref_stage (
      .clk       (clk),
      .rst_n     (rst_n),
      .pd_active (pd_active),
      .pd_mode   (pd_mode),
      .sw_en     (reg_ref_en),
      .cfg_ok    (1'b1),
      .lock_ok   (lock_seen),
      .ctl_q     (ref_ctl)
   );

   assign pll_run      = pll_run_q;
   assign mult_exp     = mult_q;
   assign spread_on    = spread_q;
   assign spread_width = width_q;
   assign ss_en        = ss_ctl.en;
   assign ss_lvl       = ss_ctl.lvl;
   assign ss_hiz       = ss_ctl.hiz;
   assign ref_en       = ref_ctl.en;
   assign ref_lvl      = ref_ctl.lvl;
   assign ref_hiz      = ref_ctl.hiz;

   // R8: stopping the PLL forgets any earlier lock
   assert_stop_clears_lock_R8: assert property (@(negedge clk) disable iff (!rst_n)
      !pll_run_q |=> !lock_seen);

   // R3: an invalid input range yields no frequency
   assert_invalid_range_R3: assert property (@(negedge clk) disable iff (!rst_n)
      (!pd_active && !ir_valid) |=> (mult_exp == NO_FREQ && !ss_en));

   // R6: power-down always stops the PLL
   assert_pd_stops_pll_R6: assert property (@(negedge clk) disable iff (!rst_n)
      pd_active |=> !pll_run);

   // R1: with software source, the register spread bit decides
   assert_sw_spread_R1: assert property (@(negedge clk) disable iff (!rst_n)
      (sel_sw && reg_spread_off) |=> !spread_on);

endmodule

// File: tb/outclk_mode_ctrl_tb.sv
module outclk_mode_ctrl_tb;

   localparam int CLK_P = 10;
   localparam int NV    = 15;

   // row: sw pir por pmw rir ror rmw sen ren | mult ss{en,lvl,hiz} ref{en,lvl,hiz}
   localparam logic [25:0] VEC [NV] = '{
      {1'b0, 2'b01, 2'b01, 3'b000, 2'b11, 2'b00, 3'b110, 1'b1, 1'b1, 3'b000, 3'b100, 3'b100},
      {1'b0, 2'b01, 2'b11, 3'b000, 2'b11, 2'b00, 3'b110, 1'b1, 1'b1, 3'b010, 3'b100, 3'b100},
      {1'b0, 2'b11, 2'b01, 3'b000, 2'b11, 2'b00, 3'b110, 1'b1, 1'b1, 3'b110, 3'b100, 3'b100},
      {1'b1, 2'b00, 2'b00, 3'b000, 2'b10, 2'b10, 3'b000, 1'b1, 1'b1, 3'b000, 3'b100, 3'b100},
      {1'b1, 2'b00, 2'b00, 3'b000, 2'b11, 2'b10, 3'b000, 1'b1, 1'b1, 3'b111, 3'b100, 3'b100},
      {1'b1, 2'b00, 2'b00, 3'b000, 2'b10, 2'b11, 3'b000, 1'b1, 1'b1, 3'b001, 3'b100, 3'b100},
      {1'b0, 2'b01, 2'b00, 3'b100, 2'b01, 2'b01, 3'b000, 1'b1, 1'b1, 3'b100, 3'b001, 3'b001},
      {1'b0, 2'b01, 2'b00, 3'b110, 2'b01, 2'b01, 3'b000, 1'b1, 1'b1, 3'b100, 3'b000, 3'b000},
      {1'b0, 2'b01, 2'b00, 3'b000, 2'b01, 2'b01, 3'b000, 1'b1, 1'b1, 3'b100, 3'b010, 3'b010},
      {1'b0, 2'b01, 2'b00, 3'b011, 2'b01, 2'b01, 3'b000, 1'b1, 1'b1, 3'b100, 3'b000, 3'b000},
      {1'b0, 2'b00, 2'b10, 3'b000, 2'b01, 2'b01, 3'b000, 1'b1, 1'b1, 3'b100, 3'b000, 3'b100},
      {1'b0, 2'b01, 2'b01, 3'b000, 2'b01, 2'b01, 3'b000, 1'b0, 1'b1, 3'b000, 3'b000, 3'b100},
      {1'b0, 2'b01, 2'b01, 3'b000, 2'b01, 2'b01, 3'b000, 1'b1, 1'b0, 3'b000, 3'b100, 3'b000},
      {1'b0, 2'b01, 2'b00, 3'b000, 2'b01, 2'b01, 3'b000, 1'b0, 1'b0, 3'b100, 3'b010, 3'b010},
      {1'b1, 2'b01, 2'b01, 3'b000, 2'b01, 2'b00, 3'b100, 1'b1, 1'b1, 3'b100, 3'b001, 3'b001}
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sel_sw = 1'b0;
   logic [1:0] pin_irange = 2'b01, pin_orange = 2'b01;
   logic [2:0] pin_mwidth = 3'b000;
   logic       pin_spread_n = 1'b0;
   logic [1:0] reg_irange = 2'b01, reg_orange = 2'b01;
   logic [2:0] reg_mwidth = 3'b000;
   logic       reg_spread_off = 1'b0;
   logic       reg_pll_run = 1'b1;
   logic       reg_ss_en = 1'b1, reg_ref_en = 1'b1;
   logic       pll_locked = 1'b1;

   logic       pll_run, spread_on;
   logic [2:0] mult_exp, spread_width;
   logic       ss_en, ss_lvl, ss_hiz, ref_en, ref_lvl, ref_hiz;

   int checks = 0;
   int errors = 0;

   always #(CLK_P / 2) clk = ~clk;

   outclk_mode_ctrl u_dut (
      .clk (clk), .rst_n (rst_n), .sel_sw (sel_sw),
      .pin_irange (pin_irange), .pin_orange (pin_orange),
      .pin_mwidth (pin_mwidth), .pin_spread_n (pin_spread_n),
      .reg_irange (reg_irange), .reg_orange (reg_orange),
      .reg_mwidth (reg_mwidth), .reg_spread_off (reg_spread_off),
      .reg_pll_run (reg_pll_run), .reg_ss_en (reg_ss_en),
      .reg_ref_en (reg_ref_en), .pll_locked (pll_locked),
      .pll_run (pll_run), .mult_exp (mult_exp), .spread_on (spread_on),
      .spread_width (spread_width),
      .ss_en (ss_en), .ss_lvl (ss_lvl), .ss_hiz (ss_hiz),
      .ref_en (ref_en), .ref_lvl (ref_lvl), .ref_hiz (ref_hiz)
   );

   task automatic chk(input string req, input logic [8:0] act, input logic [8:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%b expected=%b", req, act, exp);
      end
   endtask

   // drive just after a rising edge
   task automatic at_rise();
      @(posedge clk);
      #1;
   endtask

   // let several falling edges pass, then sample mid high-phase
   task automatic settle();
      repeat (4) @(posedge clk);
      #2;
   endtask

   initial begin
      #(CLK_P * 20000);
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      // R10: reset state
      repeat (3) @(posedge clk);
      #2;
      chk("R10 outputs in reset", {mult_exp, ss_en, ss_lvl, ss_hiz, ref_en, ref_lvl, ref_hiz},
          {3'b100, 6'b000000});
      chk("R10 run/spread in reset", {7'b0, pll_run, spread_on}, 9'b0);
      at_rise();
      rst_n = 1'b1;
      settle();

      // table walk: R1 R2 R3 R4 R5
      for (int i = 0; i < NV; i++) begin
         logic [2:0] em, es, er;
         at_rise();
         {sel_sw, pin_irange, pin_orange, pin_mwidth, reg_irange, reg_orange, reg_mwidth,
          reg_ss_en, reg_ref_en, em, es, er} = VEC[i];
         settle();
         chk($sformatf("R1/R2/R3/R4/R5 row %0d", i),
             {mult_exp, ss_en, ss_lvl, ss_hiz, ref_en, ref_lvl, ref_hiz}, {em, es, er});
      end

      // R6: PLL run request
      at_rise();
      sel_sw = 1'b0; pin_irange = 2'b01; pin_orange = 2'b01; pin_mwidth = 3'b000;
      reg_ss_en = 1'b1; reg_ref_en = 1'b1; reg_pll_run = 1'b0;
      settle();
      chk("R6 run bit low", {8'b0, pll_run}, 9'd0);
      at_rise(); reg_pll_run = 1'b1; settle();
      chk("R6 run bit high", {8'b0, pll_run}, 9'd1);
      at_rise(); pin_orange = 2'b00; settle();
      chk("R6 power-down stops PLL", {8'b0, pll_run}, 9'd0);
      at_rise(); pin_orange = 2'b01; settle();

      // R7: spread control and width
      at_rise(); pin_spread_n = 1'b0; reg_spread_off = 1'b1; pin_mwidth = 3'b101; settle();
      chk("R7 pin spread on", {5'b0, spread_on, spread_width}, {5'b0, 1'b1, 3'b101});
      at_rise(); pin_spread_n = 1'b1; reg_spread_off = 1'b0; settle();
      chk("R7 pin spread off", {5'b0, spread_on, spread_width}, {5'b0, 1'b0, 3'b101});
      at_rise(); sel_sw = 1'b1; reg_irange = 2'b01; reg_orange = 2'b01; reg_mwidth = 3'b011;
      settle();
      chk("R7 register spread on", {5'b0, spread_on, spread_width}, {5'b0, 1'b1, 3'b011});
      at_rise(); sel_sw = 1'b0; pin_mwidth = 3'b000; pin_spread_n = 1'b0; settle();

      // R8: lock gating
      at_rise(); reg_pll_run = 1'b0; pll_locked = 1'b0; settle();
      at_rise(); reg_pll_run = 1'b1; settle();
      chk("R8 no lock yet", {6'b0, ss_en, ss_lvl, ss_hiz}, 9'b000);
      chk("R8 reference ignores lock", {6'b0, ref_en, ref_lvl, ref_hiz}, 9'b100);
      at_rise(); pll_locked = 1'b1; settle();
      chk("R8 lock seen", {6'b0, ss_en, ss_lvl, ss_hiz}, 9'b100);
      at_rise(); pll_locked = 1'b0; settle();
      chk("R8 lock sticky", {6'b0, ss_en, ss_lvl, ss_hiz}, 9'b100);
      at_rise(); reg_pll_run = 1'b0; settle();
      at_rise(); reg_pll_run = 1'b1; settle();
      chk("R8 restart clears lock", {6'b0, ss_en, ss_lvl, ss_hiz}, 9'b000);
      at_rise(); pll_locked = 1'b1; settle();

      // R9: change waits for the falling edge
      at_rise();
      reg_ref_en = 1'b0;
      #2;
      chk("R9 unchanged before falling edge", {8'b0, ref_en}, 9'd1);
      @(negedge clk);
      #1;
      chk("R9 changed after falling edge", {8'b0, ref_en}, 9'd0);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule